// File: doc/BRIEF.md
# Delay-line lock and force sequencer

This block brings a memory PHY delay-locked loop out of reset and pins its delay. After a start pulse it issues a fixed series of one-cycle register writes to the PHY. First it loads the base word into control register 0. It then loads a caller-supplied word into control register 1. Next it rewrites control 0 with the enable bit set, and then rewrites it again with the run bit added. After that it samples the PHY status word once per cycle until the three lock flags are all set.

When lock is seen, the block takes the coarse lock value from the status word and merges it into the top byte of the running control word. The merged word is the final control 0 write, and it forces the delay line to hold that value. A done flag then rises and stays high. An optional poll limit turns a missing lock into a sticky error flag instead of an endless wait. Either flag is cleared by the next start, which runs the whole series again.

Top module: `dll_force_seq`

## Requirements
- R1: While reset is high and after its release, with no start, both write strobes, done_o and err_o are 0.
- R2: A start_i sampled high in the idle, done or error state produces, on the next cycle, a one-cycle wr0_o with wdata0_o = 0x00101000.
- R3: On the cycle after that, wr1_o pulses for one cycle with wdata1_o equal to ctl1_cfg_i.
- R4: On the next cycle, wr0_o pulses with wdata0_o = 0x00101002 (bit 1, the enable, added).
- R5: On the next cycle, wr0_o pulses with wdata0_o = 0x00101003 (bit 0, the run bit, added). These four writes fall in four consecutive cycles.
- R6: Lock is taken only when status bits 2:0 all read 1. The first status sample is at the clock edge after the R5 write. Patterns with only some of these bits set (011, 110, 101) keep the block polling.
- R7: In the cycle after the edge that samples lock, wr0_o pulses with wdata0_o = 0x00101003 | (status[13:6] << 24). No other status bit reaches the word.
- R8: done_o rises in the cycle after the forced write and holds. The next start clears it one cycle after being sampled and restarts the series from R2.
- R9: A start_i pulse while a series is in progress is ignored: no extra write appears and the series ends as it would have.
- R10: With POLL_LIMIT = L > 0, if lock is absent on L consecutive samples, err_o rises L cycles after the R5 write and no forced write follows. A lock seen on sample L-1 still succeeds. err_o holds until the next start clears it, and err_o and done_o are never high together.
- R11: wr0_o and wr1_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a lock series (accepted when idle, done or failed) |
| ctl1_cfg_i | input | CTL_W | Word written to PHY control register 1 |
| stat_i | input | STAT_W | PHY status word: bits 2:0 lock flags, bits 13:6 coarse lock value |
| wr0_o | output | 1 | One-cycle write strobe for PHY control register 0 |
| wdata0_o | output | CTL_W | Data for the control 0 write |
| wr1_o | output | 1 | One-cycle write strobe for PHY control register 1 |
| wdata1_o | output | CTL_W | Data for the control 1 write |
| done_o | output | 1 | Lock forced; holds until the next start |
| err_o | output | 1 | Poll limit reached without lock; holds until the next start |

## Verification
The assertions assume that stat_i is a fully known word on every edge where the block polls. They also assume ctl1_cfg_i is steady on the edge that issues the control 1 write. The bench meets both assumptions with a PHY model that drives the whole status word on each falling edge: junk in the unused fields, a chosen partial pattern in the flags until a programmed delay after the run write, and a fixed coarse value. Start pulses and the control 1 word are also driven only on falling edges and held for a full cycle, so every sampled input is stable at the rising edge.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTL1,
    ST_ON,
    ST_RUN,
    ST_POLL,
    ST_SEAL,
    ST_DONE,
    ST_FAIL
  } dfs_state_t;

endpackage

// File: rtl/dfs_word_build.sv
module dfs_word_build
  import dfs_pkg::*;
#(
  parameter int unsigned       CTL_W     = 32,
  parameter logic [CTL_W-1:0]  INIT_WORD = 32'h0010_1000,
  parameter int unsigned       ON_BIT    = 1,
  parameter int unsigned       RUN_BIT   = 0,
  parameter int unsigned       LV_W      = 8,
  parameter int unsigned       FORCE_LSB = 24
) (
  input  dfs_state_t        state_i,
  input  logic [LV_W-1:0]   lv_i,
  output logic [CTL_W-1:0]  word_o
);

  localparam logic [CTL_W-1:0] ON_MASK  = CTL_W'(1) << ON_BIT;
  localparam logic [CTL_W-1:0] RUN_MASK = CTL_W'(1) << RUN_BIT;

  logic [CTL_W-1:0] lv_field;

  always_comb begin
    lv_field = CTL_W'(lv_i) << FORCE_LSB;
    unique case (state_i)
      ST_ON:   word_o = INIT_WORD | ON_MASK;
      ST_RUN:  word_o = INIT_WORD | ON_MASK | RUN_MASK;
      ST_POLL: word_o = INIT_WORD | ON_MASK | RUN_MASK | lv_field;
      default: word_o = INIT_WORD;
    endcase
  end

endmodule

// File: rtl/dfs_lock_watch.sv
module dfs_lock_watch #(
  parameter int unsigned STAT_W     = 32,
  parameter int unsigned FLAG_W     = 3,
  parameter int unsigned LOCK_LSB   = 6,
  parameter int unsigned LV_W       = 8,
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              clear_i,
  input  logic              active_i,
  output logic              locked_o,
  output logic [LV_W-1:0]   lv_o,
  output logic              timeout_o
);

  localparam int unsigned CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic unused_stat;
  assign unused_stat = ^stat_i;

  assign locked_o = &stat_i[FLAG_W-1:0];
  assign lv_o     = stat_i[LOCK_LSB +: LV_W];

  generate
    if (POLL_LIMIT == 0) begin : g_nolimit
      assign timeout_o = 1'b0;
    end else begin : g_limit
      logic [CNT_W-1:0] miss_cnt;

      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          miss_cnt <= '0;
        end else if (active_i && !locked_o) begin
          miss_cnt <= miss_cnt + 1'b1;
        end
      end

      assign timeout_o = active_i && !locked_o &&
                         (miss_cnt == CNT_W'(POLL_LIMIT - 1));

      // R10: the miss counter starts from zero for each new poll phase
      assert_miss_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (miss_cnt == '0));
    end
  endgenerate

endmodule

// File: rtl/dfs_seq_fsm.sv
module dfs_seq_fsm
  import dfs_pkg::*;
#(
  parameter int unsigned CTL_W     = 32,
  parameter int unsigned LV_W      = 8,
  parameter int unsigned FORCE_LSB = 24,
  parameter int unsigned ON_BIT    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CTL_W-1:0] cfg1_i,
  input  logic [CTL_W-1:0] word_i,
  input  logic             locked_i,
  input  logic [LV_W-1:0]  lv_i,
  input  logic             timeout_i,
  output dfs_state_t       state_o,
  output logic             poll_clear_o,
  output logic             poll_active_o,
  output logic             wr0_o,
  output logic [CTL_W-1:0] d0_o,
  output logic             wr1_o,
  output logic [CTL_W-1:0] d1_o,
  output logic             done_o,
  output logic             err_o
);

  dfs_state_t state_q;

  assign state_o       = state_q;
  assign poll_clear_o  = (state_q == ST_RUN);
  assign poll_active_o = (state_q == ST_POLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr0_o   <= 1'b0;
      wr1_o   <= 1'b0;
      d0_o    <= '0;
      d1_o    <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      wr0_o <= 1'b0;
      wr1_o <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start_i) begin
            wr0_o   <= 1'b1;
            d0_o    <= word_i;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            state_q <= ST_CTL1;
          end
        end
        ST_CTL1: begin
          wr1_o   <= 1'b1;
          d1_o    <= cfg1_i;
          state_q <= ST_ON;
        end
        ST_ON: begin
          wr0_o   <= 1'b1;
          d0_o    <= word_i;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          wr0_o   <= 1'b1;
          d0_o    <= word_i;
          state_q <= ST_POLL;
        end
        ST_POLL: begin
          if (locked_i) begin
            wr0_o   <= 1'b1;
            d0_o    <= word_i;
            state_q <= ST_SEAL;
          end else if (timeout_i) begin
            err_o   <= 1'b1;
            state_q <= ST_FAIL;
          end
        end
        ST_SEAL: begin
          done_o  <= 1'b1;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: the two register ports never write together
  assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr0_o && wr1_o));

  // R4: the control 1 write is followed by the enable write on control 0
  assert_enable_follows_R4: assert property (@(posedge clk) disable iff (rst)
    wr1_o |=> (wr0_o && d0_o[ON_BIT]));

  // R7: the forced word carries the lock value sampled at the lock edge
  assert_force_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (poll_active_o && locked_i) |=> (wr0_o && (d0_o[FORCE_LSB +: LV_W] == $past(lv_i))));

  // R8: done only rises right after a control 0 write
  assert_done_after_force_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(wr0_o));

  // R10: error and done are exclusive
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  // R10: error only rises after a poll sample without lock
  assert_err_no_lock_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !$past(locked_i));

endmodule

// File: rtl/dll_force_seq.sv
module dll_force_seq
  import dfs_pkg::*;
#(
  parameter int unsigned       CTL_W      = 32,
  parameter int unsigned       STAT_W     = 32,
  parameter logic [CTL_W-1:0]  INIT_WORD  = 32'h0010_1000,
  parameter int unsigned       ON_BIT     = 1,
  parameter int unsigned       RUN_BIT    = 0,
  parameter int unsigned       FLAG_W     = 3,
  parameter int unsigned       LOCK_LSB   = 6,
  parameter int unsigned       LV_W       = 8,
  parameter int unsigned       FORCE_LSB  = 24,
  parameter int unsigned       POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CTL_W-1:0]  ctl1_cfg_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              wr0_o,
  output logic [CTL_W-1:0]  wdata0_o,
  output logic              wr1_o,
  output logic [CTL_W-1:0]  wdata1_o,
  output logic              done_o,
  output logic              err_o
);

  dfs_state_t       state;
  logic [CTL_W-1:0] word;
  logic             locked;
  logic [LV_W-1:0]  lv;
  logic             timeout;
  logic             poll_clear;
  logic             poll_active;

  dfs_lock_watch #(
    .STAT_W     (STAT_W),
    .FLAG_W     (FLAG_W),
    .LOCK_LSB   (LOCK_LSB),
    .LV_W       (LV_W),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_watch (
    .clk       (clk),
    .rst       (rst),
    .stat_i    (stat_i),
    .clear_i   (poll_clear),
    .active_i  (poll_active),
    .locked_o  (locked),
    .lv_o      (lv),
    .timeout_o (timeout)
  );

  dfs_word_build #(
    .CTL_W     (CTL_W),
    .INIT_WORD (INIT_WORD),
    .ON_BIT    (ON_BIT),
    .RUN_BIT   (RUN_BIT),
    .LV_W      (LV_W),
    .FORCE_LSB (FORCE_LSB)
  ) u_word (
    .state_i (state),
    .lv_i    (lv),
    .word_o  (word)
  );

  dfs_seq_fsm #(
    .CTL_W     (CTL_W),
    .LV_W      (LV_W),
    .FORCE_LSB (FORCE_LSB),
    .ON_BIT    (ON_BIT)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .cfg1_i        (ctl1_cfg_i),
    .word_i        (word),
    .locked_i      (locked),
    .lv_i          (lv),
    .timeout_i     (timeout),
    .state_o       (state),
    .poll_clear_o  (poll_clear),
    .poll_active_o (poll_active),
    .wr0_o         (wr0_o),
    .d0_o          (wdata0_o),
    .wr1_o         (wr1_o),
    .d1_o          (wdata1_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/dll_force_seq_test.sv
module dll_force_seq_test;

  localparam int          LIMIT = 16;
  localparam logic [31:0] INIT  = 32'h0010_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] ctl1_cfg_i = '0;
  logic [31:0] stat_i = '0;
  logic        wr0_o, wr1_o, done_o, err_o;
  logic [31:0] wdata0_o, wdata1_o;

  always #2 clk = ~clk;

  dll_force_seq #(.POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .ctl1_cfg_i(ctl1_cfg_i),
    .stat_i(stat_i), .wr0_o(wr0_o), .wdata0_o(wdata0_o), .wr1_o(wr1_o),
    .wdata1_o(wdata1_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PHY model and write log, updated on falling edges
  int          ncyc = 0;
  int          log_n = 0;
  int          log_ch [0:15];
  logic [31:0] log_dat [0:15];
  int          log_t [0:15];
  int          done_t = -1;
  int          err_t = -1;
  int          dual = 0;
  bit          armed = 0;
  int          lock_at = 0;
  int          dly = 0;
  logic [7:0]  lvv = '0;
  logic [2:0]  prelo = '0;
  logic        done_prev = 0, err_prev = 0;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (wr0_o && wr1_o) dual = dual + 1;
    if ((wr0_o || wr1_o) && log_n < 16) begin
      log_ch[log_n]  = wr1_o ? 1 : 0;
      log_dat[log_n] = wr1_o ? wdata1_o : wdata0_o;
      log_t[log_n]   = ncyc;
      log_n = log_n + 1;
    end
    if (wr0_o && wdata0_o == INIT) armed = 0;
    if (wr0_o && wdata0_o == (INIT | 32'h3) && !armed) begin
      armed = 1;
      lock_at = ncyc + dly;
    end
    if (done_o && !done_prev) done_t = ncyc;
    if (err_o && !err_prev) err_t = ncyc;
    done_prev = done_o;
    err_prev = err_o;
    stat_i = {18'h2_A5C3, lvv, 3'b101,
              (armed && ncyc >= lock_at) ? 3'b111 : prelo};
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    check("R1", "wr0 in reset", {31'b0, wr0_o}, 32'd0);
    check("R1", "done in reset", {31'b0, done_o}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "writes after reset", log_n, 0);
    check("R1", "wr1 after reset", {31'b0, wr1_o}, 32'd0);
    check("R1", "flags after reset", {30'b0, done_o, err_o}, 32'd0);
  endtask

  task automatic run_seq(input string tag, input logic [31:0] cfg, input int d,
                         input logic [7:0] lv, input logic [2:0] pl,
                         input int busy_at, input bit expect_ok);
    int s;
    @(negedge clk);
    #1;
    ctl1_cfg_i = cfg; dly = d; lvv = lv; prelo = pl;
    log_n = 0; done_t = -1; err_t = -1;
    start_i = 1'b1;
    s = ncyc;
    @(negedge clk);
    #1;
    start_i = 1'b0;
    check("R8", {tag, " done cleared by start"}, {31'b0, done_o}, 32'd0);
    check("R10", {tag, " err cleared by start"}, {31'b0, err_o}, 32'd0);
    for (int k = 2; k < 44; k++) begin
      @(negedge clk);
      #1;
      start_i = (k == busy_at);
    end
    start_i = 1'b0;
    check("R9", {tag, " write count"}, log_n, expect_ok ? 5 : 4);
    check("R2", {tag, " first write port"}, log_ch[0], 0);
    check("R2", {tag, " base word"}, log_dat[0], INIT);
    check("R2", {tag, " base write cycle"}, log_t[0], s + 1);
    check("R3", {tag, " ctl1 port"}, log_ch[1], 1);
    check("R3", {tag, " ctl1 data"}, log_dat[1], cfg);
    check("R3", {tag, " ctl1 cycle"}, log_t[1], s + 2);
    check("R4", {tag, " enable word"}, log_dat[2], INIT | 32'h2);
    check("R4", {tag, " enable cycle"}, log_t[2], s + 3);
    check("R5", {tag, " run word"}, log_dat[3], INIT | 32'h3);
    check("R5", {tag, " run cycle"}, log_t[3], s + 4);
    check("R11", {tag, " dual strobes"}, dual, 0);
    if (expect_ok) begin
      check("R7", {tag, " forced word"}, log_dat[4], INIT | 32'h3 | ({24'b0, lv} << 24));
      check("R6", {tag, " force cycle"}, log_t[4], lock_at + 1);
      check("R8", {tag, " done rise cycle"}, done_t, lock_at + 2);
      check("R8", {tag, " done held"}, {31'b0, done_o}, 32'd1);
      check("R10", {tag, " no err"}, {31'b0, err_o}, 32'd0);
    end else begin
      check("R10", {tag, " err rise cycle"}, err_t, log_t[3] + LIMIT);
      check("R10", {tag, " err held"}, {31'b0, err_o}, 32'd1);
      check("R10", {tag, " no done"}, {31'b0, done_o}, 32'd0);
    end
  endtask

  initial begin
    t_reset();
    run_seq("basic",     32'h0000_0086, 3,         8'hA7, 3'b000, 0, 1'b1);
    run_seq("restart",   32'h0000_0085, 0,         8'h3C, 3'b000, 0, 1'b1);
    run_seq("part011",   32'h1234_5678, 5,         8'h01, 3'b011, 0, 1'b1);
    run_seq("part110",   32'h0000_0086, 6,         8'hFF, 3'b110, 0, 1'b1);
    run_seq("part101",   32'h0000_0085, 4,         8'h00, 3'b101, 0, 1'b1);
    run_seq("busy_ctl",  32'hCAFE_0001, 7,         8'h5A, 3'b000, 2, 1'b1);
    run_seq("busy_poll", 32'hCAFE_0002, 9,         8'h96, 3'b000, 8, 1'b1);
    run_seq("timeout",   32'h0000_0086, LIMIT,     8'h42, 3'b011, 0, 1'b0);
    run_seq("edge_ok",   32'h0000_0085, LIMIT - 1, 8'hC3, 3'b000, 0, 1'b1);
    run_seq("never",     32'h0000_0086, 1000,      8'h11, 3'b000, 0, 1'b0);
    run_seq("recover",   32'h0000_0085, 2,         8'h77, 3'b110, 0, 1'b1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule